// File: doc/BRIEF.md
# Priority Interrupt Controller with Priority Stack

This block is a vectored interrupt controller for one processor. A set of level-sensitive request sources, each formed by the OR of a hardware line and a software-settable bit, carries its own 4-bit priority. The controller raises a single interrupt request to the processor whenever the best pending priority is strictly above a current-priority register. The processor learns the winning source by reading an acknowledge register. That read also saves the old current priority on a hardware stack and raises the current priority to that of the acknowledged source. An end-of-interrupt write pops the saved priority back.

Acknowledging a source never clears it. The source stays pending until its hardware line or software bit drops, and it requests again as soon as the current priority falls below it. Beside the priority logic sits a non-maskable path. A double-synchronized pin with a programmable active edge sets a sticky flag, and that flag drives a critical-interrupt output. Only the processor's own critical-enable input gates this output.

Top module: `prio_intc`

## Requirements
- R1: `irq_o` is high exactly when some pending source has a priority strictly greater than the current priority (register at address 0, bits [3:0]). A pending source with priority 0 never raises `irq_o`.
- R2: When several pending sources share the highest priority, the one with the lowest index wins. A read of address 1 returns the winner's index in bits [7:0] while `irq_o` is high.
- R3: A read of address 1 while `irq_o` is high pushes the current priority onto the stack and loads the current priority with the winner's priority in the same cycle. While `irq_o` is low the read returns 0xFF and changes nothing.
- R4: Acknowledging does not clear a source. A source that is still pending raises `irq_o` again once the current priority drops below its priority.
- R5: Any write to address 2 pops the top of the stack into the current priority. On an empty stack it sets the current priority to 0.
- R6: The stack holds 16 entries. A push while it is full is dropped, and the stored entries are left unchanged.
- R7: Address 3 is a read/write register of software request bits, bit i for source i. Each bit is ORed with `hw_req[i]`. Address 16+i holds the priority of source i in bits [3:0]. A write to address 0 sets the current priority directly.
- R8: Address 4 controls the non-maskable path: bit0 enable, bit1 edge select (0 rising, 1 falling), bit2 sticky flag. A selected edge on `nmi_pin` sets the flag after the third rising clock edge following the pin change, but only while enable is 1.
- R9: `crit_o` equals the sticky flag ANDed with `cpu_crit_en`. It does not depend on any priority, current-priority or request setting.
- R10: Writing 1 to bit2 of address 4 clears the flag. If a detected edge falls in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | NUM_SRC | Level-sensitive hardware request lines |
| nmi_pin | input | 1 | Asynchronous non-maskable pin |
| cpu_crit_en | input | 1 | Processor critical-interrupt enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| crit_o | output | 1 | Critical interrupt request to the processor |

## Verification
The non-maskable detector and the register bus can act on the sticky flag in the same cycle: a synchronized edge sets it while a software write clears it. The bench changes the pin, waits exactly two clock edges so that the detected edge lines up with the next bus write, and issues the clearing write in that cycle. It then expects the flag to read back as 1 and `crit_o` to stay high. A separate check confirms that the same clear, issued with no edge present, does drop the flag.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int PRIO_W  = 4;
    localparam int A_CUR   = 0;
    localparam int A_ACK   = 1;
    localparam int A_EOI   = 2;
    localparam int A_SWREQ = 3;
    localparam int A_NMI   = 4;
    localparam int A_PRIO  = 16;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output prio_t                          best_prio,
    output logic [IDX_W-1:0]               best_idx,
    output logic                           valid
);
    logic [NUM_SRC-1:0][PRIO_W-1:0] eff;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        assign eff[g] = pend[g] ? prio[g] : '0;
    end

    always_comb begin
        best_prio = '0;
        best_idx  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eff[i] > best_prio) begin
                best_prio = eff[i];
                best_idx  = IDX_W'(i);
            end
        end
        valid = (best_prio != '0);
    end
endmodule

// File: rtl/intc_lifo.sv
module intc_lifo
    import prio_intc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  logic  pop,
    input  prio_t din,
    output prio_t top,
    output logic  empty
);
    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
    } lifo_t;

    lifo_t r_q, r_d;
    logic  full;

    assign empty = (r_q.cnt == '0);
    assign full  = (r_q.cnt == CNT_W'(DEPTH));
    assign top   = empty ? '0 : r_q.mem[r_q.cnt - 1'b1];

    always_comb begin
        r_d = r_q;
        if (push && !full) begin
            r_d.mem[r_q.cnt] = din;
            r_d.cnt          = r_q.cnt + 1'b1;
        end else if (pop && !push && !empty) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (r_q.cnt == $past(r_q.cnt))); // R6
endmodule

// File: rtl/intc_nmi_edge.sv
module intc_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic en,
    input  logic fall_sel,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic flag;
    } nmi_t;

    nmi_t r_q, r_d;
    logic edge_hit;

    assign edge_hit = en && (fall_sel ? (!r_q.s2 && r_q.s3) : (r_q.s2 && !r_q.s3));
    assign flag     = r_q.flag;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = pin;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
        if (clr)      r_d.flag = 1'b0;
        if (edge_hit) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> r_q.flag); // R10
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int DEPTH  = 1 << PRIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               nmi_pin,
    input  logic               cpu_crit_en,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic               crit_o
);
    typedef struct packed {
        prio_t                          cur;
        logic [NUM_SRC-1:0]             sw;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic                           nmi_en;
        logic                           nmi_fall;
    } regs_t;

    regs_t r_q, r_d;

    logic [NUM_SRC-1:0] src_pend;
    prio_t              best_prio;
    logic [IDX_W-1:0]   win_idx;
    logic               win_valid;
    prio_t              lifo_top;
    logic               lifo_empty;
    logic               nmi_flag;
    logic               wr_en, rd_ack, ack_take, eoi, nmi_clr;

    assign src_pend = hw_req | r_q.sw;
    assign wr_en    = bus_sel && bus_wr;
    assign rd_ack   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(A_ACK));
    assign irq_o    = win_valid && (best_prio > r_q.cur);
    assign ack_take = rd_ack && irq_o;
    assign eoi      = wr_en && (bus_addr == ADDR_W'(A_EOI));
    assign nmi_clr  = wr_en && (bus_addr == ADDR_W'(A_NMI)) && bus_wdata[2];
    assign crit_o   = nmi_flag && cpu_crit_en;

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend      (src_pend),
        .prio      (r_q.prio),
        .best_prio (best_prio),
        .best_idx  (win_idx),
        .valid     (win_valid)
    );

    intc_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ack_take),
        .pop   (eoi),
        .din   (r_q.cur),
        .top   (lifo_top),
        .empty (lifo_empty)
    );

    intc_nmi_edge u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (nmi_pin),
        .en       (r_q.nmi_en),
        .fall_sel (r_q.nmi_fall),
        .clr      (nmi_clr),
        .flag     (nmi_flag)
    );

    always_comb begin
        r_d = r_q;
        if (ack_take) r_d.cur = best_prio;
        if (eoi)      r_d.cur = lifo_empty ? '0 : lifo_top;
        if (wr_en) begin
            if (bus_addr == ADDR_W'(A_CUR))   r_d.cur = bus_wdata[PRIO_W-1:0];
            if (bus_addr == ADDR_W'(A_SWREQ)) r_d.sw  = bus_wdata[NUM_SRC-1:0];
            if (bus_addr == ADDR_W'(A_NMI)) begin
                r_d.nmi_en   = bus_wdata[0];
                r_d.nmi_fall = bus_wdata[1];
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_addr == ADDR_W'(A_PRIO + i)) r_d.prio[i] = bus_wdata[PRIO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            A_CUR:   bus_rdata = DATA_W'(r_q.cur);
            A_ACK:   bus_rdata = irq_o ? DATA_W'(win_idx) : {DATA_W{1'b1}};
            A_SWREQ: bus_rdata = DATA_W'(r_q.sw);
            A_NMI:   bus_rdata = DATA_W'({nmi_flag, r_q.nmi_fall, r_q.nmi_en});
            default: begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (bus_addr == ADDR_W'(A_PRIO + i)) bus_rdata = DATA_W'(r_q.prio[i]);
                end
            end
        endcase
    end

    AST_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (r_q.cur == $past(best_prio))); // R3
    AST_EOI_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && lifo_empty) |=> (r_q.cur == '0)); // R5
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> src_pend[win_idx]); // R2
endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] hw_req = '0;
    logic         nmi_pin = 1'b0;
    logic         cpu_crit_en = 1'b1;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic         irq_o, crit_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .nmi_pin(nmi_pin),
        .cpu_crit_en(cpu_crit_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .crit_o(crit_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'(a);
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic irq_is(input string req, input string what, input int exp);
        @(negedge clk); #1;
        check(req, what, int'(irq_o), exp);
    endtask

    task automatic t_reset();
        int v;
        #1;
        check("R1", "irq after reset", int'(irq_o), 0);
        check("R9", "crit after reset", int'(crit_o), 0);
        rd(0, v); check("R7", "cur after reset", v, 0);
        rd(1, v); check("R3", "ack idle returns null", v, 255);
        rd(0, v); check("R3", "idle ack leaves cur", v, 0);
    endtask

    task automatic t_threshold();
        wr(16 + 3, 5);
        hw_req = 8'b0000_1000;
        irq_is("R1", "prio5 over cur0", 1);
        wr(0, 5);
        irq_is("R1", "prio5 equal cur5", 0);
        wr(0, 4);
        irq_is("R1", "prio5 over cur4", 1);
        wr(0, 0);
        hw_req = 8'b1000_0000;
        irq_is("R1", "prio0 source never requests", 0);
        hw_req = '0;
    endtask

    task automatic t_tie();
        int v;
        wr(16 + 2, 7); wr(16 + 5, 7); wr(16 + 6, 3);
        hw_req = 8'b0110_0100;
        rd(1, v); check("R2", "tie lowest index", v, 2);
        rd(0, v); check("R3", "cur after tie ack", v, 7);
        wr(2, 0);
        rd(0, v); check("R5", "eoi restores 0", v, 0);
        hw_req = '0;
    endtask

    task automatic t_nest();
        int v;
        wr(16 + 1, 4); wr(16 + 4, 9);
        hw_req = 8'b0000_0010;
        rd(1, v); check("R2", "ack vector src1", v, 1);
        rd(0, v); check("R3", "cur loaded 4", v, 4);
        irq_is("R1", "no request above cur", 0);
        hw_req = 8'b0001_0010;
        irq_is("R1", "preempting src4", 1);
        rd(1, v); check("R2", "ack vector src4", v, 4);
        rd(0, v); check("R3", "cur loaded 9", v, 9);
        wr(2, 0);
        rd(0, v); check("R5", "pop to 4", v, 4);
        irq_is("R4", "src4 still pending re-requests", 1);
        hw_req = 8'b0000_0010;
        wr(2, 0);
        rd(0, v); check("R5", "pop to 0", v, 0);
        irq_is("R4", "uncleared src1 re-requests", 1);
        wr(2, 0);
        rd(0, v); check("R5", "empty pop gives 0", v, 0);
        wr(0, 15);
        rd(1, v); check("R3", "ack below cur null", v, 255);
        rd(0, v); check("R3", "null ack keeps cur", v, 15);
        wr(0, 0);
        hw_req = '0;
        irq_is("R4", "cleared source gone", 0);
    endtask

    task automatic t_lifo_full();
        int v;
        wr(3, 1); wr(16 + 0, 15);
        for (int j = 0; j < 17; j++) begin
            wr(0, j % 15);
            rd(1, v); check("R6", "fill ack vector", v, 0);
        end
        for (int k = 0; k < 17; k++) begin
            wr(2, 0);
            rd(0, v);
            check("R6", "pop order after overflow", v, (k < 16) ? ((15 - k) % 15) : 0);
        end
        wr(3, 0); wr(0, 0);
    endtask

    task automatic t_sw();
        int v;
        wr(16 + 6, 2);
        wr(3, 8'h40);
        rd(3, v); check("R7", "sw readback", v, 8'h40);
        irq_is("R7", "sw bit requests", 1);
        rd(1, v); check("R7", "sw ack vector", v, 6);
        wr(2, 0);
        wr(3, 0);
        irq_is("R7", "sw bit cleared", 0);
    endtask

    task automatic t_nmi();
        int v;
        wr(4, 1);
        @(negedge clk); nmi_pin = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk); #1;
        check("R8", "flag not yet after two edges", int'(crit_o), 0);
        @(posedge clk); @(negedge clk); #1;
        check("R8", "rising edge sets crit", int'(crit_o), 1);
        wr(0, 15); wr(16 + 0, 0);
        #1 check("R9", "crit ignores priority regs", int'(crit_o), 1);
        wr(0, 0);
        cpu_crit_en = 1'b0;
        #1 check("R9", "cpu enable gates crit", int'(crit_o), 0);
        rd(4, v); check("R8", "flag held while gated", v, 5);
        cpu_crit_en = 1'b1;
        wr(4, 5);
        rd(4, v); check("R10", "w1c clears flag", v, 1);
        wr(4, 3);
        @(negedge clk); nmi_pin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R8", "falling edge sets crit", int'(crit_o), 1);
        wr(4, 6);
        @(negedge clk); nmi_pin = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk); nmi_pin = 1'b0;
        repeat (4) @(posedge clk);
        rd(4, v); check("R8", "disabled path no flag", v, 2);
        wr(4, 0);
    endtask

    task automatic t_set_wins();
        int v;
        wr(4, 5);
        rd(4, v); check("R10", "flag clear before race", v, 1);
        @(negedge clk); nmi_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(4, 5);
        rd(4, v); check("R10", "set wins over clear", v, 5);
        #1 check("R10", "crit kept after race", int'(crit_o), 1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_threshold();
        t_tie();
        t_nest();
        t_lifo_full();
        t_sw();
        t_nmi();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule